// File: doc/BRIEF.md
# Channel Status and User Data Double Buffer

This block sits beside the serializer of a digital audio transmitter of the IEC-60958 type. It stores two 192-bit side fields: the channel status block and the user data block. Software writes each field as six 32-bit words. The serializer steps through one frame at a time. For each frame the block supplies one status bit and one user bit, and it wraps back to the first frame after frame 191.

Each field has two copies. Software writes into a register copy. The serializer reads from a shadow copy. While the transmitter is disabled, the shadow copy follows the register copy, so writes take effect directly. While the transmitter runs, the shadow copy is reloaded only at a block boundary, so a block on the line never mixes old and new content.

Each field has its own ready flag. A flag rises when its shadow copy has just been loaded, which means the next rewrite is safe. A write to that field clears the flag again. A one-cycle pulse marks the end of every 192-frame block.

Top module: `csub_buffer`

## Requirements
- R1: After reset the register and shadow copies of both fields are zero. Both outputs read 0, both ready flags read 1, the block-end pulse is 0 and the frame position is 0.
- R2: Word w of a field (wordSel = 0..5) holds field bits 32w+31..32w. Byte 0 of each word sits in bits 7:0 and byte 3 in bits 31:24. wrField = 0 selects channel status and wrField = 1 selects user data.
- R3: While txEnable is low, the frame position stays at 0 and the shadow copies are reloaded from the registers on every cycle. A write therefore appears on the outputs two clock edges after it is presented.
- R4: In frame n (0..191), statusBit carries bit n of the channel status shadow and userBit carries bit n of the user data shadow. Bit 0 of a byte goes out first, bytes go out in ascending order, and words go out in ascending order.
- R5: While transmitting, the frame position advances by one on each cycle with frameTick high, and holds when frameTick is low.
- R6: A frameTick during frame 191 returns the position to frame 0. blockEnd is then high for exactly the one following cycle, and it is low at all other times.
- R7: While transmitting, the shadow copies change only on a frameTick during frame 191, when they take the register contents. Writes made during a block show up only from the next block on.
- R8: While transmitting, each ready flag is set when its shadow is loaded at a block boundary and is cleared by a valid write to its own field only.
- R9: If a write and the block-boundary load fall in the same cycle, the load takes the register contents from before the write, and that field's ready flag ends up cleared.
- R10: A write with wordSel of 6 or more changes no register and no ready flag.
- R11: Dropping txEnable returns the frame position to 0 and sets both ready flags on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEnable | input | 1 | Transmitter running |
| frameTick | input | 1 | Current frame has been sent; advance to the next frame |
| wrEn | input | 1 | Register write strobe |
| wrField | input | 1 | 0 = channel status, 1 = user data |
| wordSel | input | 3 | Word index within the field (0..5 valid) |
| wrData | input | 32 | Write data |
| statusBit | output | 1 | Channel status bit for the current frame |
| userBit | output | 1 | User data bit for the current frame |
| csReady | output | 1 | Channel status field may be rewritten |
| udReady | output | 1 | User data field may be rewritten |
| blockEnd | output | 1 | One-cycle pulse after the last frame of a block |

## Verification
A software write can fall in the same cycle as the block-boundary load. In that cycle the ready flag is both set and cleared, and the shadow copy must choose between the old and the new word. The bench drives a user data write on the exact cycle of the frameTick that ends frame 191. It then judges three things: the ready flag must read 0, the whole following block must still carry the old user word, and the block after that must carry the new word. A second overlap, a write issued while the position is held between ticks, checks that the current block does not change.

// File: rtl/csub_pkg.sv
package csub_pkg;
  localparam int CSUB_WORD_W = 32;
  localparam int CSUB_WORDS  = 6;

  // strobes from the frame controller to the field storage
  typedef struct packed {
    logic loadShadow;
  } csub_strobe_t;
endpackage

// File: rtl/csub_ctrl.sv
module csub_ctrl
  import csub_pkg::*;
#(
  parameter int FRAMES = 192,
  parameter int IDX_W  = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEnable,
  input  logic             frameTick,
  input  logic             csWrite,
  input  logic             udWrite,
  output csub_strobe_t     strb,
  output logic [IDX_W-1:0] frameIdx,
  output logic             csReady,
  output logic             udReady,
  output logic             blockEnd
);
  logic lastFrame;
  logic boundary;

  assign lastFrame       = (frameIdx == IDX_W'(FRAMES - 1));
  assign boundary        = frameTick && lastFrame;
  assign strb.loadShadow = !txEnable || boundary;

  always_ff @(posedge clk) begin
    if (!rstN || !txEnable) begin
      frameIdx <= '0;
      csReady  <= 1'b1;
      udReady  <= 1'b1;
      blockEnd <= 1'b0;
    end else begin
      blockEnd <= boundary;
      if (frameTick)
        frameIdx <= lastFrame ? '0 : frameIdx + IDX_W'(1);
      // a write in the load cycle wins: its content is not in the shadow
      if (csWrite)       csReady <= 1'b0;
      else if (boundary) csReady <= 1'b1;
      if (udWrite)       udReady <= 1'b0;
      else if (boundary) udReady <= 1'b1;
    end
  end

  p_frame_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    frameIdx < IDX_W'(FRAMES));
  p_block_end_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    blockEnd |-> frameIdx == '0);
  p_write_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && csWrite) |=> !csReady);
  p_collision_r9: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && udWrite && boundary) |=> (!udReady && frameIdx == '0));
  p_disable_ready_r11: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> (csReady && udReady && frameIdx == '0));
endmodule

// File: rtl/csub_dp.sv
module csub_dp
  import csub_pkg::*;
#(
  parameter int WORDS   = CSUB_WORDS,
  parameter int WORD_W  = CSUB_WORD_W,
  parameter int FIELD_W = WORDS * WORD_W,
  parameter int IDX_W   = $clog2(FIELD_W),
  parameter int SEL_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrField,
  input  logic [SEL_W-1:0]  wordSel,
  input  logic [WORD_W-1:0] wrData,
  input  csub_strobe_t      strb,
  input  logic [IDX_W-1:0]  frameIdx,
  output logic              csWrite,
  output logic              udWrite,
  output logic              statusBit,
  output logic              userBit
);
  logic              selValid;
  logic [WORD_W-1:0] csWord [WORDS];
  logic [WORD_W-1:0] udWord [WORDS];
  logic [FIELD_W-1:0] csFlat, udFlat;
  logic [FIELD_W-1:0] csShadow, udShadow;

  assign selValid = int'(wordSel) < WORDS;
  assign csWrite  = wrEn && !wrField && selValid;
  assign udWrite  = wrEn &&  wrField && selValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < WORDS; w++) begin
        csWord[w] <= '0;
        udWord[w] <= '0;
      end
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        if (csWrite && wordSel == SEL_W'(w)) csWord[w] <= wrData;
        if (udWrite && wordSel == SEL_W'(w)) udWord[w] <= wrData;
      end
    end
  end

  // word w occupies field bits [w*WORD_W +: WORD_W]; bit 0 is sent first
  for (genvar w = 0; w < WORDS; w++) begin : g_pack
    assign csFlat[w*WORD_W +: WORD_W] = csWord[w];
    assign udFlat[w*WORD_W +: WORD_W] = udWord[w];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csShadow <= '0;
      udShadow <= '0;
    end else if (strb.loadShadow) begin
      csShadow <= csFlat;
      udShadow <= udFlat;
    end
  end

  assign statusBit = csShadow[frameIdx];
  assign userBit   = udShadow[frameIdx];

  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadShadow |=> ($stable(csShadow) && $stable(udShadow)));
  p_bad_index_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !selValid) |=> ($stable(csFlat) && $stable(udFlat)));
endmodule

// File: rtl/csub_buffer.sv
module csub_buffer
  import csub_pkg::*;
#(
  parameter int WORDS  = CSUB_WORDS,
  parameter int WORD_W = CSUB_WORD_W,
  localparam int FIELD_W = WORDS * WORD_W,
  localparam int IDX_W   = $clog2(FIELD_W),
  localparam int SEL_W   = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic              frameTick,
  input  logic              wrEn,
  input  logic              wrField,
  input  logic [SEL_W-1:0]  wordSel,
  input  logic [WORD_W-1:0] wrData,
  output logic              statusBit,
  output logic              userBit,
  output logic              csReady,
  output logic              udReady,
  output logic              blockEnd
);
  csub_strobe_t     strb;
  logic [IDX_W-1:0] frameIdx;
  logic             csWrite, udWrite;

  csub_ctrl #(.FRAMES(FIELD_W), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .frameTick(frameTick),
    .csWrite(csWrite), .udWrite(udWrite), .strb(strb), .frameIdx(frameIdx),
    .csReady(csReady), .udReady(udReady), .blockEnd(blockEnd)
  );

  csub_dp #(.WORDS(WORDS), .WORD_W(WORD_W), .FIELD_W(FIELD_W),
            .IDX_W(IDX_W), .SEL_W(SEL_W)) dp_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrField(wrField),
    .wordSel(wordSel), .wrData(wrData), .strb(strb), .frameIdx(frameIdx),
    .csWrite(csWrite), .udWrite(udWrite),
    .statusBit(statusBit), .userBit(userBit)
  );
endmodule

// File: tb/csub_buffer_tb_top.sv
module csub_buffer_tb_top;
  logic clk = 1'b0;
  logic rstN, txEnable, frameTick, wrEn, wrField;
  logic [2:0]  wordSel;
  logic [31:0] wrData;
  logic statusBit, userBit, csReady, udReady, blockEnd;

  int checks = 0;
  int errors = 0;

  logic [191:0] regCs, regUd, expCs, expUd;
  logic [31:0]  wordD;

  always #4 clk = ~clk;

  csub_buffer dut_i (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .frameTick(frameTick),
    .wrEn(wrEn), .wrField(wrField), .wordSel(wordSel), .wrData(wrData),
    .statusBit(statusBit), .userBit(userBit), .csReady(csReady),
    .udReady(udReady), .blockEnd(blockEnd)
  );

  task automatic chk(input logic ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic fld, input int idx, input logic [31:0] d);
    wrEn = 1'b1; wrField = fld; wordSel = 3'(idx); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (idx < 6) begin
      if (fld) regUd[32*idx +: 32] = d;
      else     regCs[32*idx +: 32] = d;
    end
  endtask

  function automatic logic [31:0] patA(input int w);
    return (32'h9E37_79B1 * 32'(w + 1)) ^ (32'(w) << 12);
  endfunction
  function automatic logic [31:0] patB(input int w);
    return (32'h6C07_8965 * 32'(w + 3)) ^ 32'h0000_00A5;
  endfunction

  task automatic runBlock(input int blk, input int lastN);
    logic [191:0] nextCs, nextUd;
    for (int n = 0; n <= lastN; n++) begin
      chk(statusBit == expCs[n], $sformatf("R4 status blk%0d frame%0d", blk, n),
          32'(statusBit), 32'(expCs[n]));
      chk(userBit == expUd[n], $sformatf("R4 user blk%0d frame%0d", blk, n),
          32'(userBit), 32'(expUd[n]));
      if (n > 0) chk(!blockEnd, "R6 no pulse mid-block", 32'(blockEnd), 0);
      if (blk == 1 && n == 40) begin
        repeat (3) @(negedge clk);
        chk(statusBit == expCs[n] && userBit == expUd[n], "R5 hold without tick",
            {statusBit, userBit}, {expCs[n], expUd[n]});
      end
      if (blk == 1 && n == 100) begin
        doWrite(1'b0, 2, 32'h5A5A_0FF0);
        chk(!csReady, "R8 cs write clears csReady", 32'(csReady), 0);
        chk(udReady, "R8 udReady untouched by cs write", 32'(udReady), 1);
        doWrite(1'b1, 6, 32'hFFFF_FFFF);
        chk(udReady, "R10 bad index leaves udReady", 32'(udReady), 1);
        chk(statusBit == expCs[n], "R7 current block unchanged",
            32'(statusBit), 32'(expCs[n]));
      end
      if (n == 191) begin
        nextCs = regCs;
        nextUd = regUd;
        if (blk == 2) begin
          // write lands in the same cycle as the boundary load (R9)
          wrEn = 1'b1; wrField = 1'b1; wordSel = 3'd0; wrData = wordD;
        end
        frameTick = 1'b1;
        @(negedge clk);
        frameTick = 1'b0;
        if (blk == 2) begin
          wrEn = 1'b0;
          regUd[31:0] = wordD;
        end
        expCs = nextCs;
        expUd = nextUd;
        chk(blockEnd, "R6 pulse after frame 191", 32'(blockEnd), 1);
        chk(csReady, "R8 csReady set at load", 32'(csReady), 1);
        chk(udReady == (blk != 2), "R9 collision leaves udReady cleared",
            32'(udReady), 32'(blk != 2));
        chk(statusBit == expCs[0], "R6 wrap to frame 0", 32'(statusBit), 32'(expCs[0]));
        @(negedge clk);
        chk(!blockEnd, "R6 pulse lasts one cycle", 32'(blockEnd), 0);
      end else begin
        frameTick = 1'b1;
        @(negedge clk);
        frameTick = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; txEnable = 1'b0; frameTick = 1'b0;
    wrEn = 1'b0; wrField = 1'b0; wordSel = '0; wrData = '0;
    regCs = '0; regUd = '0;
    wordD = 32'hC3D2_E1F0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!statusBit && !userBit, "R1 outputs zero", {statusBit, userBit}, 0);
    chk(csReady && udReady, "R1 ready flags high", {csReady, udReady}, 32'h3);
    chk(!blockEnd, "R1 no block end", 32'(blockEnd), 0);

    // disabled: writes reach the outputs directly (R2, R3)
    for (int w = 0; w < 6; w++) begin
      doWrite(1'b0, w, patA(w) | (w == 0 ? 32'h1 : 32'h0));
      doWrite(1'b1, w, patB(w) | (w == 0 ? 32'h1 : 32'h0));
    end
    @(negedge clk);
    chk(statusBit == regCs[0], "R3 disabled cs write visible", 32'(statusBit), 32'(regCs[0]));
    chk(userBit == regUd[0], "R3 disabled ud write visible", 32'(userBit), 32'(regUd[0]));
    doWrite(1'b0, 6, 32'hFFFF_FFFF);
    doWrite(1'b1, 7, 32'hFFFF_FFFF);
    @(negedge clk);
    expCs = regCs;
    expUd = regUd;

    txEnable = 1'b1;
    @(negedge clk);
    chk(csReady && udReady, "R8 flags high at start", {csReady, udReady}, 32'h3);
    runBlock(1, 191);   // R2 R4 R10 over every frame
    runBlock(2, 191);   // block with rewritten cs word 2 (R7)
    runBlock(3, 191);   // ud still old content after collision (R9)
    runBlock(4, 60);    // ud word 0 now carries the late write

    txEnable = 1'b0;
    @(negedge clk);
    chk(csReady && udReady, "R11 disable sets flags", {csReady, udReady}, 32'h3);
    chk(statusBit == regCs[0] && userBit == regUd[0], "R11 back to frame 0",
        {statusBit, userBit}, {regCs[0], regUd[0]});
    chk(!blockEnd, "R11 no pulse on disable", 32'(blockEnd), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule